// File: doc/BRIEF.md
# PHY Register Handshake Master

This block lets on-chip logic read and write the 16-bit configuration registers of a PHY. These registers have no memory-mapped access. The only path to them is a 32-bit control word, which the block drives, and a 32-bit status word, which the block samples. Every transfer across that pair is a four-phase handshake. The block raises a strobe and waits for the acknowledge flag to go high. It then withdraws the strobe and waits for the flag to go low.

A command carries a direction, a 16-bit register address and, for writes, 16-bit data. The block runs an address-capture handshake first. A write then runs a data-capture handshake followed by a write-strobe handshake. A read runs a read-strobe handshake and keeps the 16 bits that the PHY presents beside the acknowledge. The result of a command is either a one-cycle done pulse or a one-cycle timeout error.

Each acknowledge wait takes a bounded number of samples, spaced a fixed number of clocks apart. By default the spacing is one microsecond at the configured clock frequency. If the expected level never shows, the command is abandoned. The status word passes through a synchronizer before it is compared, so the PHY may run from its own clock.

Top module: `phy_hs_master`

## Requirements
- R1: After reset, phy_ctrl is all zeros, busy, done and timeout_err are low, cmd_ready is high and rd_data is zero.
- R2: Control word bits 15:0 carry the address or data payload. Bit 16 is the address-capture strobe, bit 17 the data-capture strobe, bit 18 the write strobe and bit 19 the read strobe. All bits above 19 are always zero and at most one strobe is set at a time. The status word carries the acknowledge in bit 16 and read data in bits 15:0.
- R3: Every command begins with the same sequence of distinct control values. These are the address alone, then the address with bit 16 set until the acknowledge is seen high, then the address alone until the acknowledge is seen low.
- R4: A write continues with the following distinct control values: data, data with bit 17, data, bit 18 alone, data, and finally zero. Each strobe is held until the acknowledge is seen high, and each strobe-free value that follows it is held until the acknowledge is seen low.
- R5: A read continues with bit 19 alone until the acknowledge is seen high, then zero until it is seen low. rd_data takes the status bits 15:0 present with that acknowledge. rd_data keeps that value through later writes and failed commands.
- R6: Each acknowledge wait samples at most MAX_SAMPLES times. The first sample falls in the cycle the waited-on control value appears, and later samples follow every SAMPLE_GAP cycles. If the last sample misses, timeout_err pulses one cycle later.
- R7: In the cycle timeout_err is high, phy_ctrl is zero and done is low. busy is low in the next cycle, and a following command completes normally.
- R8: A command is taken only when cmd_valid is high while cmd_ready is high. busy is high from the cycle after acceptance until the done or error cycle. cmd_valid while busy has no effect.
- R9: Each completed command produces exactly one done cycle, with phy_ctrl zero in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | One-cycle acknowledge timeout pulse |
| rd_data | output | 16 | Data of the last successful read |
| phy_ctrl | output | CTRL_W | Control word to the PHY |
| phy_stat | input | STAT_W | Status word from the PHY |

## Verification
The bench logs every distinct control value of a command and compares the log with the full expected handshake. A design that skipped the release phase of any handshake, or left a strobe set alongside payload, would produce a different log. Timeouts are forced at the address capture, at the read strobe and at a release wait where the acknowledge never drops. The bench also forces a timeout with a PHY slower than the sampling window. The error cycle is measured against the sampling window, so an off-by-one sample count or gap shows up as a wrong cycle. A command issued mid-transfer must leave the target register untouched, and rd_data must survive writes and failed reads; a design that latched the wrong command or overwrote rd_data on any acknowledge would fail these checks.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

   // payload field shared by address and data
   localparam int unsigned PAYLOAD_W    = 16;
   // strobe bit positions decoded by the PHY
   localparam int unsigned BIT_CAP_ADDR = 16;
   localparam int unsigned BIT_CAP_DATA = 17;
   localparam int unsigned BIT_WR       = 18;
   localparam int unsigned BIT_RD       = 19;
   // acknowledge flag position in the status word
   localparam int unsigned BIT_ACK      = 16;
   localparam int unsigned CTRL_MIN_W   = BIT_RD + 1;
   localparam int unsigned STAT_USED_W  = BIT_ACK + 1;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADR_SET,
      ST_ADR_CAP,
      ST_ADR_REL,
      ST_WD_SET,
      ST_WD_CAP,
      ST_WD_REL,
      ST_WR_STB,
      ST_WR_REL,
      ST_RD_STB,
      ST_RD_REL,
      ST_FIN,
      ST_ABORT
   } step_e;

   typedef struct packed {
      logic                 is_write;
      logic [PAYLOAD_W-1:0] addr;
      logic [PAYLOAD_W-1:0] wdata;
   } cmd_t;

endpackage

// File: rtl/phy_hs_sync.sv
module phy_hs_sync #(
   parameter int unsigned W      = 17,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/phy_hs_ackwait.sv
module phy_hs_ackwait #(
   parameter int unsigned GAP   = 100,
   parameter int unsigned TRIES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,      // a wait step is active
   input  logic arm,     // first cycle of a new wait step
   input  logic want,    // expected acknowledge level
   input  logic ack,     // synchronized acknowledge
   output logic hit,
   output logic expire
);

   localparam int unsigned GAP_W = (GAP > 1) ? $clog2(GAP) : 1;
   localparam int unsigned TRY_W = (TRIES > 1) ? $clog2(TRIES) : 1;

   logic [GAP_W-1:0] gap_q;
   logic             sample_now;
   logic             match;
   logic             last_try;

   assign sample_now = en & (arm | (gap_q == '0));
   assign match      = (ack == want);
   assign hit        = sample_now & match;
   assign expire     = sample_now & ~match & last_try;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  gap_q <= '0;
      else if (sample_now)         gap_q <= GAP_W'(GAP - 1);
      else if (en && gap_q != '0)  gap_q <= gap_q - GAP_W'(1);
   end

   generate
      if (TRIES == 1) begin : g_single
         assign last_try = 1'b1;
      end else begin : g_count
         logic [TRY_W-1:0] tries_q;
         logic [TRY_W-1:0] tries_now;
         assign tries_now = arm ? '0 : tries_q;
         assign last_try  = (tries_now == TRY_W'(TRIES - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          tries_q <= '0;
            else if (sample_now) tries_q <= tries_now + TRY_W'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/phy_hs_seq.sv
module phy_hs_seq
   import phy_hs_pkg::*;
#(
   parameter int unsigned CTRL_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  cmd_t                 cmd_in,
   input  logic                 ack_hit,
   input  logic                 ack_expire,
   input  logic [PAYLOAD_W-1:0] stat_payload,
   output logic                 wait_en,
   output logic                 wait_arm,
   output logic                 wait_want,
   output logic                 busy,
   output logic                 done,
   output logic                 err,
   output logic [PAYLOAD_W-1:0] rd_data,
   output logic [CTRL_W-1:0]    ctrl
);

   step_e                state_q, state_d;
   cmd_t                 cmd_q, cmd_d;
   logic                 arm_q;
   logic [CTRL_W-1:0]    ctrl_q;
   logic [PAYLOAD_W-1:0] rd_q;

   function automatic logic is_wait(input step_e s);
      case (s)
         ST_ADR_CAP, ST_ADR_REL, ST_WD_CAP, ST_WD_REL,
         ST_WR_STB, ST_WR_REL, ST_RD_STB, ST_RD_REL: is_wait = 1'b1;
         default:                                    is_wait = 1'b0;
      endcase
   endfunction

   function automatic logic wants_high(input step_e s);
      case (s)
         ST_ADR_CAP, ST_WD_CAP, ST_WR_STB, ST_RD_STB: wants_high = 1'b1;
         default:                                     wants_high = 1'b0;
      endcase
   endfunction

   function automatic logic [CTRL_W-1:0] word_for(input step_e s, input cmd_t c);
      logic [CTRL_W-1:0] w;
      w = '0;
      case (s)
         ST_ADR_SET, ST_ADR_REL: w[PAYLOAD_W-1:0] = c.addr;
         ST_ADR_CAP: begin
            w[PAYLOAD_W-1:0] = c.addr;
            w[BIT_CAP_ADDR]  = 1'b1;
         end
         ST_WD_SET, ST_WD_REL, ST_WR_REL: w[PAYLOAD_W-1:0] = c.wdata;
         ST_WD_CAP: begin
            w[PAYLOAD_W-1:0] = c.wdata;
            w[BIT_CAP_DATA]  = 1'b1;
         end
         ST_WR_STB: w[BIT_WR] = 1'b1;
         ST_RD_STB: w[BIT_RD] = 1'b1;
         default: ;
      endcase
      return w;
   endfunction

   always_comb begin
      state_d = state_q;
      cmd_d   = cmd_q;
      case (state_q)
         ST_IDLE: if (cmd_valid) begin
            state_d = ST_ADR_SET;
            cmd_d   = cmd_in;
         end
         ST_ADR_SET: state_d = ST_ADR_CAP;
         ST_ADR_CAP: if (ack_hit) state_d = ST_ADR_REL;
         ST_ADR_REL: if (ack_hit) state_d = cmd_q.is_write ? ST_WD_SET : ST_RD_STB;
         ST_WD_SET:  state_d = ST_WD_CAP;
         ST_WD_CAP:  if (ack_hit) state_d = ST_WD_REL;
         ST_WD_REL:  if (ack_hit) state_d = ST_WR_STB;
         ST_WR_STB:  if (ack_hit) state_d = ST_WR_REL;
         ST_WR_REL:  if (ack_hit) state_d = ST_FIN;
         ST_RD_STB:  if (ack_hit) state_d = ST_RD_REL;
         ST_RD_REL:  if (ack_hit) state_d = ST_FIN;
         default:    state_d = ST_IDLE;
      endcase
      if (is_wait(state_q) && ack_expire) state_d = ST_ABORT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd_q   <= '0;
         arm_q   <= 1'b0;
         ctrl_q  <= '0;
         rd_q    <= '0;
      end else begin
         state_q <= state_d;
         cmd_q   <= cmd_d;
         arm_q   <= is_wait(state_d) && (state_d != state_q);
         ctrl_q  <= word_for(state_d, cmd_d);
         if (state_q == ST_RD_STB && ack_hit) rd_q <= stat_payload;
      end
   end

   assign wait_en   = is_wait(state_q);
   assign wait_arm  = arm_q;
   assign wait_want = wants_high(state_q);
   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_FIN);
   assign err       = (state_q == ST_ABORT);
   assign rd_data   = rd_q;
   assign ctrl      = ctrl_q;

endmodule

// File: rtl/phy_hs_master.sv
module phy_hs_master
   import phy_hs_pkg::*;
#(
   parameter int unsigned CTRL_W      = 32,
   parameter int unsigned STAT_W      = 32,
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned SAMPLE_GAP  = CLK_HZ / 1_000_000,
   parameter int unsigned MAX_SAMPLES = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic                 cmd_write,
   input  logic [PAYLOAD_W-1:0] cmd_addr,
   input  logic [PAYLOAD_W-1:0] cmd_wdata,
   output logic                 busy,
   output logic                 done,
   output logic                 timeout_err,
   output logic [PAYLOAD_W-1:0] rd_data,
   output logic [CTRL_W-1:0]    phy_ctrl,
   input  logic [STAT_W-1:0]    phy_stat
);

   localparam int unsigned SYNC_W = STAT_USED_W;

   if (CTRL_W < CTRL_MIN_W) begin : g_bad_ctrl_w
      $error("CTRL_W too narrow for the strobe field");
   end
   if (STAT_W < SYNC_W) begin : g_bad_stat_w
      $error("STAT_W too narrow for the acknowledge flag");
   end
   if (SAMPLE_GAP < 1) begin : g_bad_gap
      $error("SAMPLE_GAP must be at least one cycle");
   end
   if (MAX_SAMPLES < 1) begin : g_bad_tries
      $error("MAX_SAMPLES must be at least one");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least two");
   end

   logic [SYNC_W-1:0] stat_s;
   logic              wait_en, wait_arm, wait_want;
   logic              ack_hit, ack_expire;
   cmd_t              cmd_in;

   generate
      if (STAT_W > SYNC_W) begin : g_stat_hi
         logic unused_stat_hi;
         assign unused_stat_hi = ^phy_stat[STAT_W-1:SYNC_W];
      end
   endgenerate

   assign cmd_in = '{is_write: cmd_write, addr: cmd_addr, wdata: cmd_wdata};

   phy_hs_sync #(
      .W      (SYNC_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (phy_stat[SYNC_W-1:0]),
      .q     (stat_s)
   );

   phy_hs_ackwait #(
      .GAP   (SAMPLE_GAP),
      .TRIES (MAX_SAMPLES)
   ) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (wait_en),
      .arm    (wait_arm),
      .want   (wait_want),
      .ack    (stat_s[BIT_ACK]),
      .hit    (ack_hit),
      .expire (ack_expire)
   );

   phy_hs_seq #(
      .CTRL_W (CTRL_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_in       (cmd_in),
      .ack_hit      (ack_hit),
      .ack_expire   (ack_expire),
      .stat_payload (stat_s[PAYLOAD_W-1:0]),
      .wait_en      (wait_en),
      .wait_arm     (wait_arm),
      .wait_want    (wait_want),
      .busy         (busy),
      .done         (done),
      .err          (timeout_err),
      .rd_data      (rd_data),
      .ctrl         (phy_ctrl)
   );

   assign cmd_ready = ~busy;

endmodule

// File: rtl/phy_hs_master_chk.sv
module phy_hs_master_chk #(
   parameter int unsigned CTRL_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              busy,
   input logic              done,
   input logic              timeout_err,
   input logic [15:0]       rd_data,
   input logic [CTRL_W-1:0] phy_ctrl
);

   // R2
   strobe_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phy_ctrl[19:16]) && ((phy_ctrl >> 20) == '0));

   // R4
   wr_strobe_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_ctrl[18] |-> (phy_ctrl[15:0] == 16'h0));

   // R8
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> busy);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_valid) |=> !busy);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (phy_ctrl == '0) && !timeout_err);

   // R7
   err_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> (phy_ctrl == '0));

   // R7
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |=> !busy);

   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(rd_data));

endmodule

bind phy_hs_master phy_hs_master_chk #(.CTRL_W(CTRL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .busy        (busy),
   .done        (done),
   .timeout_err (timeout_err),
   .rd_data     (rd_data),
   .phy_ctrl    (phy_ctrl)
);

// File: tb/phy_hs_master_test.sv
module phy_hs_master_test;

   localparam int CLK_PERIOD = 10;
   localparam int GAP        = 4;
   localparam int TRIES      = 10;
   localparam int ERR_DELAY  = (TRIES - 1) * GAP + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_write = 1'b0;
   logic [15:0] cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic        cmd_ready, busy, done, timeout_err;
   logic [15:0] rd_data;
   logic [31:0] phy_ctrl;
   logic [31:0] phy_stat;

   int n_checks = 0;
   int n_bad    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_hs_master #(
      .SAMPLE_GAP  (GAP),
      .MAX_SAMPLES (TRIES)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_ready   (cmd_ready),
      .cmd_write   (cmd_write),
      .cmd_addr    (cmd_addr),
      .cmd_wdata   (cmd_wdata),
      .busy        (busy),
      .done        (done),
      .timeout_err (timeout_err),
      .rd_data     (rd_data),
      .phy_ctrl    (phy_ctrl),
      .phy_stat    (phy_stat)
   );

   // ---------------- PHY model ----------------
   int          lat = 1;
   logic [3:0]  mute = 4'b0000;
   logic        stuck = 1'b0;
   logic [15:0] regs [16];
   logic [15:0] lat_addr, lat_data, rdat;
   logic        ack;
   int          cnt;

   assign phy_stat = {15'h0, ack, rdat};

   always @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0; cnt <= 0; rdat <= '0; lat_addr <= '0; lat_data <= '0;
         for (int i = 0; i < 16; i++) regs[i] <= '0;
      end else if (!ack && phy_ctrl[19:16] != 4'b0 && (phy_ctrl[19:16] & mute) == 4'b0) begin
         if (cnt >= lat) begin
            cnt <= 0;
            ack <= 1'b1;
            if (phy_ctrl[16]) lat_addr <= phy_ctrl[15:0];
            if (phy_ctrl[17]) lat_data <= phy_ctrl[15:0];
            if (phy_ctrl[18]) regs[lat_addr[3:0]] <= lat_data;
            if (phy_ctrl[19]) rdat <= regs[lat_addr[3:0]];
         end else cnt <= cnt + 1;
      end else if (ack && phy_ctrl[19:16] == 4'b0 && !stuck) begin
         if (cnt >= lat) begin cnt <= 0; ack <= 1'b0; end
         else cnt <= cnt + 1;
      end else cnt <= 0;
   end

   // ---------------- results of the last command ----------------
   logic [31:0] log_seq [16];
   int          log_n;
   logic [31:0] exp_seq [16];
   int          exp_n;
   int          r_done, r_err, r_err_k, r_cap_k, r_busy_gap, r_ready_gap;
   logic [31:0] r_ctrl_end;
   logic        r_busy_after;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic exp_push(input logic [31:0] w);
      if ((exp_n == 0) ? (w != 32'h0) : (w != exp_seq[exp_n-1])) begin
         exp_seq[exp_n] = w;
         exp_n++;
      end
   endtask

   task automatic build_exp(input logic wr, input logic [15:0] a, input logic [15:0] d);
      exp_n = 0;
      exp_push({16'h0, a});
      exp_push({16'h0, a} | 32'h1_0000);
      exp_push({16'h0, a});
      if (wr) begin
         exp_push({16'h0, d});
         exp_push({16'h0, d} | 32'h2_0000);
         exp_push({16'h0, d});
         exp_push(32'h4_0000);
         exp_push({16'h0, d});
      end else begin
         exp_push(32'h8_0000);
      end
      exp_push(32'h0);
   endtask

   task automatic do_op(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        input int inject_at);
      logic [31:0] last;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      log_n = 0; last = 32'h0;
      r_done = 0; r_err = 0; r_err_k = -1; r_cap_k = -1;
      r_busy_gap = 0; r_ready_gap = 0; r_ctrl_end = 32'hDEAD_BEEF;
      for (int k = 0; k < 3000; k++) begin
         if (phy_ctrl != last) begin
            if (log_n < 16) log_seq[log_n] = phy_ctrl;
            log_n++;
            last = phy_ctrl;
         end
         if (phy_ctrl[16] && r_cap_k < 0) r_cap_k = k;
         if (!busy) r_busy_gap++;
         if (cmd_ready) r_ready_gap++;
         if (k == inject_at) begin
            cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h000C; cmd_wdata = 16'hBEEF;
         end else begin
            cmd_valid = 1'b0;
         end
         if (done) begin r_done++; r_ctrl_end = phy_ctrl; end
         if (timeout_err) begin r_err = 1; r_err_k = k; r_ctrl_end = phy_ctrl; end
         if (done || timeout_err) break;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      @(negedge clk);
      r_busy_after = busy;
      if (done) r_done++;
   endtask

   task automatic check_log(input string req);
      chk(log_n == exp_n, req, "control value count", 32'(log_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < log_n && i < 16; i++)
         chk(log_seq[i] == exp_seq[i], req, "control value in order", log_seq[i], exp_seq[i]);
   endtask

   task automatic t_reset;
      chk(phy_ctrl == 32'h0, "R1", "phy_ctrl after reset", phy_ctrl, 32'h0);
      chk(!busy && !done && !timeout_err, "R1", "busy/done/err after reset",
          {29'h0, busy, done, timeout_err}, 32'h0);
      chk(cmd_ready, "R1", "cmd_ready after reset", 32'(cmd_ready), 32'h1);
      chk(rd_data == 16'h0, "R1", "rd_data after reset", 32'(rd_data), 32'h0);
   endtask

   task automatic t_write_read;
      do_op(1'b1, 16'h0005, 16'hA5C3, -1);
      build_exp(1'b1, 16'h0005, 16'hA5C3);
      check_log("R4");
      chk(r_done == 1 && r_err == 0, "R9", "write done count", 32'(r_done), 32'h1);
      chk(r_ctrl_end == 32'h0, "R9", "ctrl at done", r_ctrl_end, 32'h0);
      chk(r_busy_gap == 0 && r_ready_gap == 0, "R8", "busy through write",
          32'(r_busy_gap + r_ready_gap), 32'h0);
      chk(!r_busy_after, "R8", "busy after done", 32'(r_busy_after), 32'h0);
      do_op(1'b0, 16'h0005, 16'h0000, -1);
      build_exp(1'b0, 16'h0005, 16'h0);
      check_log("R3");
      chk(rd_data == 16'hA5C3, "R5", "read back", 32'(rd_data), 32'hA5C3);
      chk(r_done == 1, "R9", "read done count", 32'(r_done), 32'h1);
   endtask

   task automatic t_patterns;
      do_op(1'b1, 16'h0009, 16'hFFFF, -1);
      do_op(1'b1, 16'h000A, 16'h0001, -1);
      chk(rd_data == 16'hA5C3, "R5", "rd_data kept across writes", 32'(rd_data), 32'hA5C3);
      do_op(1'b0, 16'h0009, 16'h0, -1);
      chk(rd_data == 16'hFFFF, "R5", "read all ones", 32'(rd_data), 32'hFFFF);
      do_op(1'b0, 16'h000A, 16'h0, -1);
      chk(rd_data == 16'h0001, "R5", "read single bit", 32'(rd_data), 32'h0001);
      do_op(1'b1, 16'h000A, 16'h0000, -1);
      do_op(1'b0, 16'h000A, 16'h0, -1);
      chk(rd_data == 16'h0000, "R5", "read zero", 32'(rd_data), 32'h0);
   endtask

   task automatic t_busy_ignore;
      do_op(1'b1, 16'h0003, 16'h1234, 6);
      chk(r_done == 1, "R8", "single done with mid-command request", 32'(r_done), 32'h1);
      chk(r_busy_gap == 0, "R8", "busy held", 32'(r_busy_gap), 32'h0);
      do_op(1'b0, 16'h000C, 16'h0, -1);
      chk(rd_data == 16'h0000, "R8", "ignored command left register", 32'(rd_data), 32'h0);
      do_op(1'b0, 16'h0003, 16'h0, -1);
      chk(rd_data == 16'h1234, "R8", "accepted command wrote", 32'(rd_data), 32'h1234);
   endtask

   task automatic t_slow_ok;
      lat = 30;
      do_op(1'b1, 16'h0007, 16'h0F0F, -1);
      chk(r_done == 1 && r_err == 0, "R6", "slow PHY inside window", 32'(r_err), 32'h0);
      do_op(1'b0, 16'h0007, 16'h0, -1);
      chk(rd_data == 16'h0F0F, "R6", "slow PHY read", 32'(rd_data), 32'h0F0F);
      lat = 1;
   endtask

   task automatic t_timeout_addr;
      mute = 4'b0001;
      do_op(1'b1, 16'h0007, 16'h5555, -1);
      chk(r_err == 1 && r_done == 0, "R7", "error without done", 32'(r_done), 32'h0);
      chk(r_err_k - r_cap_k == ERR_DELAY, "R6", "error cycle after capture strobe",
          32'(r_err_k - r_cap_k), 32'(ERR_DELAY));
      chk(r_ctrl_end == 32'h0, "R7", "ctrl zero at error", r_ctrl_end, 32'h0);
      chk(!r_busy_after, "R7", "idle after error", 32'(r_busy_after), 32'h0);
      mute = 4'b0000;
      do_op(1'b0, 16'h0007, 16'h0, -1);
      chk(rd_data == 16'h0F0F, "R7", "failed write left register", 32'(rd_data), 32'h0F0F);
   endtask

   task automatic t_timeout_release;
      stuck = 1'b1;
      do_op(1'b0, 16'h0009, 16'h0, -1);
      chk(r_err == 1, "R6", "stuck acknowledge times out", 32'(r_err), 32'h1);
      chk(rd_data == 16'h0F0F, "R5", "rd_data kept on failure", 32'(rd_data), 32'h0F0F);
      stuck = 1'b0;
      repeat (10) @(negedge clk);
      do_op(1'b0, 16'h0009, 16'h0, -1);
      chk(r_done == 1 && rd_data == 16'hFFFF, "R7", "recovery read", 32'(rd_data), 32'hFFFF);
   endtask

   task automatic t_timeout_slow_and_read;
      lat = 40;
      do_op(1'b1, 16'h0009, 16'h2222, -1);
      chk(r_err == 1, "R6", "PHY slower than window", 32'(r_err), 32'h1);
      lat = 1;
      repeat (60) @(negedge clk);
      mute = 4'b1000;
      do_op(1'b0, 16'h0009, 16'h0, -1);
      chk(r_err == 1 && r_done == 0, "R6", "read strobe times out", 32'(r_err), 32'h1);
      chk(rd_data == 16'hFFFF, "R5", "rd_data kept on read timeout", 32'(rd_data), 32'hFFFF);
      mute = 4'b0000;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks + 1, n_bad + 1);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset;
      t_write_read;
      t_patterns;
      t_busy_ignore;
      t_slow_ok;
      t_timeout_addr;
      t_timeout_release;
      t_timeout_slow_and_read;
      repeat (5) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
      $finish;
   end

endmodule